// File: doc/BRIEF.md
# Configurable Peripheral Period Timer

A 16-bit up-counting timer with three registers that software writes through a simple write port: a control word, the live count and a period value. Counting stops when the enable bit is clear. While enabled, the timer advances from one of three tick sources, and each source passes through a shared prescaler:

- the bus clock itself;
- the bus clock, but only while a synchronized external gate pin is high;
- rising edges of an external pin, after a two-flop synchronizer.

An idle-stop control can pause counting while the idle input is high.

When counting brings the count to the period value, the timer raises a one-cycle match pulse and sets a sticky flag. The next counting tick returns the count to zero instead of incrementing it. In gated mode, a second sticky flag records the end of each gate window. Both flags are cleared by a single strobe.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control word and the count read 0x0000, the period reads 0xFFFF, and `match_pulse`, `irq_flag` and `gate_done` are 0.
- R2: A control write stores only the implemented bits: bit 15 enable, bit 13 idle-stop, bit 7 gate mode, bits 5:4 prescale, bit 2 sync request and bit 1 source select. The implemented mask is 0xA0B6, and every other bit reads 0.
- R3: With bit 15 at 0 the count holds its value, and the other stored control bits keep their values.
- R4: With bit 13 at 1, the count holds while `idle` is high. With bit 13 at 0, `idle` has no effect.
- R5: Bits 5:4 set the prescale ratio: 00 is 1:1, 01 is 1:8, 10 is 1:64 and 11 is 1:256. The prescaler restarts from zero whenever bit 15 is 0 or a control write occurs, and a control-write cycle produces no tick.
- R6: When a tick moves the count to a value equal to the period, `match_pulse` is high for the following cycle. On the next tick after the count equals the period, the count becomes 0x0000.
- R7: `irq_flag` is set by each match and stays set until `flag_clr` is high. A match in the same cycle as `flag_clr` leaves the flag set.
- R8: With bit 1 at 0 and bit 7 at 1, prescaler inputs occur only in cycles where the gate pin, delayed by two flops, is high. The falling edge of that synchronized gate sets `gate_done` (cleared by `flag_clr`).
- R9: With bit 1 at 1 and bit 2 at 1, each rising edge of `ext_pin` gives one prescaler input, detected after the two-flop synchronizer. Bit 7 is ignored in this mode. With bit 1 at 1 and bit 2 at 0, the count does not advance.
- R10: With bit 1 at 0, bit 2 has no effect on counting.
- R11: `wr_sel` 1 writes the count and `wr_sel` 2 writes the period. A count write takes priority over a tick in the same cycle and never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 control, 1 count, 2 period |
| wr_data | input | 16 | Write data |
| flag_clr | input | 1 | Clears both sticky flags |
| idle | input | 1 | Idle-state indication |
| ext_pin | input | 1 | Gate or external clock pin |
| ctrl_q | output | 16 | Stored control word |
| count_q | output | 16 | Current count |
| period_q | output | 16 | Period value |
| match_pulse | output | 1 | One-cycle match event |
| irq_flag | output | 1 | Sticky match flag |
| gate_done | output | 1 | Sticky end-of-gate flag |

## Verification
The hardest case to reach is a prescaler terminal tick that falls in the same cycle as a control rewrite, a count write or a flag clear. Several sticky and synchronized paths meet in that one cycle. The stimulus reaches it by writing registers at fixed offsets while the timer runs at 1:8 and 1:256 with a short period, so that writes land on and beside tick cycles. A behavioural per-cycle model resolves which effect wins. The gate and external modes toggle the pin at different rates, so the window edges fall at several prescaler phases.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int unsigned CW    = 16;
    localparam int unsigned PRE_W = 8;

    localparam logic [CW-1:0] CTRL_MASK = 16'hA0B6;

    typedef struct packed {
        logic       on;
        logic       rsv14;
        logic       sidl;
        logic [4:0] rsv12_8;
        logic       gate;
        logic       rsv6;
        logic [1:0] ckps;
        logic       rsv3;
        logic       tsync;
        logic       tcs;
        logic       rsv0;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_NONE   = 2'd3
    } wsel_e;

    function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] ckps);
        case (ckps)
            2'b00:   presc_last = PRE_W'(0);
            2'b01:   presc_last = PRE_W'(7);
            2'b10:   presc_last = PRE_W'(63);
            default: presc_last = PRE_W'(255);
        endcase
    endfunction

endpackage

// File: rtl/ptmr_edge_sync.sv
module ptmr_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign level = s2;
    assign rise  = s2 & ~s3;
    assign fall  = ~s2 & s3;

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise, fall})); // R8

endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          src,
    input  logic [PW-1:0] last,
    output logic          tick
);
    logic [PW-1:0] pre_q;

    assign tick = src & (pre_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (src) begin
            pre_q <= (pre_q == last) ? '0 : pre_q + PW'(1);
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        pre_q <= last || $past(last) != last || $past(clr)); // R5

    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> pre_q == '0); // R5

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          cnt_wr,
    input  logic          per_wr,
    input  logic [TW-1:0] wr_data,
    output logic [TW-1:0] count_q,
    output logic [TW-1:0] period_q,
    output logic          match_set,
    output logic          match_pulse
);
    logic [TW-1:0] nxt;

    assign nxt       = (count_q == period_q) ? '0 : count_q + TW'(1);
    assign match_set = tick & ~cnt_wr & (nxt == period_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q     <= '0;
            period_q    <= '1;
            match_pulse <= 1'b0;
        end else begin
            if (cnt_wr)      count_q <= wr_data;
            else if (tick)   count_q <= nxt;
            if (per_wr)      period_q <= wr_data;
            match_pulse <= match_set;
        end
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && count_q == period_q) |=> count_q == '0); // R6

    AST_WR_PRIO: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count_q == $past(wr_data) && !match_pulse)); // R11

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic        flag_clr,
    input  logic        idle,
    input  logic        ext_pin,
    output logic [15:0] ctrl_q,
    output logic [15:0] count_q,
    output logic [15:0] period_q,
    output logic        match_pulse,
    output logic        irq_flag,
    output logic        gate_done
);
    import ptmr_pkg::*;

    localparam int unsigned TW = CW;

    ctrl_t ctrl;
    logic  ctrl_wr, cnt_wr, per_wr;
    logic  run, base, src, tick, match_set;
    logic  pin_lvl, pin_rise, pin_fall;

    assign ctrl_wr = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);
    assign cnt_wr  = wr_en && (wsel_e'(wr_sel) == SEL_COUNT);
    assign per_wr  = wr_en && (wsel_e'(wr_sel) == SEL_PERIOD);

    always_ff @(posedge clk) begin
        if (rst)          ctrl <= '0;
        else if (ctrl_wr) ctrl <= ctrl_t'(wr_data & CTRL_MASK);
    end

    assign ctrl_q = ctrl;

    ptmr_edge_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (ext_pin),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    always_comb begin
        if (ctrl.tcs)       base = ctrl.tsync & pin_rise;
        else if (ctrl.gate) base = pin_lvl;
        else                base = 1'b1;
    end

    assign run = ctrl.on & ~(ctrl.sidl & idle);
    assign src = run & base & ~ctrl_wr;

    ptmr_prescale #(.PW(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (~ctrl.on | ctrl_wr),
        .src  (src),
        .last (presc_last(ctrl.ckps)),
        .tick (tick)
    );

    ptmr_counter #(.TW(TW)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .cnt_wr      (cnt_wr),
        .per_wr      (per_wr),
        .wr_data     (wr_data),
        .count_q     (count_q),
        .period_q    (period_q),
        .match_set   (match_set),
        .match_pulse (match_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag  <= 1'b0;
            gate_done <= 1'b0;
        end else begin
            if (match_set)     irq_flag <= 1'b1;
            else if (flag_clr) irq_flag <= 1'b0;
            if (ctrl.on && !ctrl.tcs && ctrl.gate && pin_fall) gate_done <= 1'b1;
            else if (flag_clr)                                  gate_done <= 1'b0;
        end
    end

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> irq_flag); // R7

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.on && !cnt_wr) |=> $stable(count_q)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sidl && idle && !cnt_wr) |=> $stable(count_q)); // R4

    AST_CTRL_MASK: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q & ~CTRL_MASK) == '0); // R2

    AST_NOSYNC_EXT: assert property (@(posedge clk) disable iff (rst)
        (ctrl.tcs && !ctrl.tsync && !cnt_wr) |=> $stable(count_q)); // R9

endmodule

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [15:0] wr_data = 16'h0;
    logic        flag_clr = 1'b0;
    logic        idle = 1'b0;
    logic        ext_pin = 1'b0;
    logic [15:0] ctrl_q, count_q, period_q;
    logic        match_pulse, irq_flag, gate_done;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    always #5 clk = ~clk;

    ptmr_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_clr(flag_clr), .idle(idle), .ext_pin(ext_pin),
        .ctrl_q(ctrl_q), .count_q(count_q), .period_q(period_q),
        .match_pulse(match_pulse), .irq_flag(irq_flag), .gate_done(gate_done)
    );

    // behavioural reference
    logic [15:0] m_ctrl, m_cnt, m_per;
    logic        m_match, m_irq, m_gd, p1, p2, p3;
    int          m_pre;

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_cnt = 0; m_per = 16'hFFFF; m_match = 0; m_irq = 0; m_gd = 0;
            p1 = 0; p2 = 0; p3 = 0; m_pre = 0;
        end else begin
            bit cw, nw, pw, base, srcv, tk, hit, gf;
            int n;
            logic [15:0] nx;
            cw = wr_en && wr_sel == 2'd0;
            nw = wr_en && wr_sel == 2'd1;
            pw = wr_en && wr_sel == 2'd2;
            if (m_ctrl[1])      base = m_ctrl[2] && p2 && !p3;
            else if (m_ctrl[7]) base = p2;
            else                base = 1;
            srcv = m_ctrl[15] && !(m_ctrl[13] && idle) && base && !cw;
            case (m_ctrl[5:4])
                2'd0: n = 1;
                2'd1: n = 8;
                2'd2: n = 64;
                default: n = 256;
            endcase
            tk = 0;
            if (!m_ctrl[15] || cw) m_pre = 0;
            else if (srcv) begin
                if (m_pre == n - 1) begin tk = 1; m_pre = 0; end
                else m_pre = m_pre + 1;
            end
            nx  = (m_cnt == m_per) ? 16'h0 : m_cnt + 16'h1;
            hit = tk && !nw && nx == m_per;
            gf  = m_ctrl[15] && !m_ctrl[1] && m_ctrl[7] && !p2 && p3;
            m_match = hit;
            m_irq = hit ? 1'b1 : (flag_clr ? 1'b0 : m_irq);
            m_gd  = gf  ? 1'b1 : (flag_clr ? 1'b0 : m_gd);
            if (nw) m_cnt = wr_data;
            else if (tk) m_cnt = nx;
            if (pw) m_per = wr_data;
            if (cw) m_ctrl = wr_data & 16'hA0B6;
            p3 = p2; p2 = p1; p1 = ext_pin;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", phase, tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("ctrl",   ctrl_q,   m_ctrl);
            chk("count",  count_q,  m_cnt);
            chk("period", period_q, m_per);
            chk("match",  {15'h0, match_pulse}, {15'h0, m_match});
            chk("irq",    {15'h0, irq_flag},    {15'h0, m_irq});
            chk("gdone",  {15'h0, gate_done},   {15'h0, m_gd});
        end
    end

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_sel = 2'd3;
    endtask

    task automatic clr_flags();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    task automatic idle_cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic pin_toggle(input int hi, input int lo, input int reps);
        for (int i = 0; i < reps; i++) begin
            @(negedge clk); ext_pin = 1; repeat (hi - 1) @(negedge clk);
            @(negedge clk); ext_pin = 0; repeat (lo - 1) @(negedge clk);
        end
    endtask

    initial begin
        logic [15:0] held;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        phase = "R1";
        chk("reset ctrl",  ctrl_q,   16'h0000);
        chk("reset count", count_q,  16'h0000);
        chk("reset per",   period_q, 16'hFFFF);
        chk("reset flags", {13'h0, match_pulse, irq_flag, gate_done}, 16'h0);
        cmp_on = 1;

        phase = "R2";
        wr(2'd0, 16'hFFFF);
        chk("mask", ctrl_q, 16'hA0B6);
        wr(2'd0, 16'h0000);

        phase = "R11";
        wr(2'd2, 16'd5);
        wr(2'd1, 16'd2);
        chk("period write", period_q, 16'd5);

        phase = "R6";
        wr(2'd0, 16'h8000);
        idle_cycles(30);
        phase = "R7";
        clr_flags();
        idle_cycles(9);
        @(negedge clk); flag_clr = 1;
        idle_cycles(6);
        flag_clr = 0;
        phase = "R11";
        wr(2'd1, 16'd4);
        wr(2'd1, 16'd5);
        idle_cycles(8);

        phase = "R3";
        wr(2'd0, 16'h2030);
        held = count_q;
        idle_cycles(12);
        chk("off hold", count_q, held);
        chk("off keep bits", ctrl_q, 16'h2030);

        phase = "R4";
        wr(2'd0, 16'hA000);
        idle = 1;
        held = count_q;
        idle_cycles(10);
        chk("idle stop", count_q, held);
        idle = 0;
        idle_cycles(5);
        wr(2'd0, 16'h8000);
        idle = 1;
        idle_cycles(10);
        idle = 0;

        phase = "R5";
        wr(2'd2, 16'd2);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h8010);
        idle_cycles(60);
        wr(2'd0, 16'h8010);
        idle_cycles(45);
        wr(2'd0, 16'h8020);
        idle_cycles(300);
        wr(2'd0, 16'h8030);
        idle_cycles(1600);

        phase = "R10";
        wr(2'd2, 16'd6);
        wr(2'd0, 16'h8004);
        idle_cycles(25);

        phase = "R8";
        clr_flags();
        wr(2'd0, 16'h8080);
        pin_toggle(12, 5, 3);
        pin_toggle(3, 7, 4);
        chk("gate done set", {15'h0, gate_done}, 16'h1);
        clr_flags();
        wr(2'd0, 16'h8090);
        pin_toggle(20, 4, 3);

        phase = "R9";
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h8086);
        pin_toggle(2, 2, 10);
        pin_toggle(1, 3, 8);
        wr(2'd0, 16'h8002);
        held = count_q;
        pin_toggle(2, 2, 8);
        chk("no sync no count", count_q, held);

        idle_cycles(5);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog %s: actual timeout expected completion", phase);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule